// File: doc/BRIEF.md
# Ethernet VLAN Header Parser

This block sits at the receive side of a switch datapath and decodes the leading bytes of each incoming Ethernet frame. Frame bytes arrive one per beat on a valid/ready stream with start-of-frame and end-of-frame markers, together with the number of the port the frame came in on. The parser always reads the first fourteen bytes as the Ethernet header. When the EtherType of that header equals the tag protocol identifier (0x8100 by default), a tag state reads four more bytes as an 802.1Q tag. Any other EtherType accepts the frame at once.

When the parser reaches a decision, it loads its output registers and pulses a result-valid strobe for one cycle. The outputs are the typed header fields, a presence flag for each header, a drop flag and the ingress port. Downstream logic discards any frame whose drop flag is set. Payload bytes after the header are consumed without being read. A frame that ends before its header is complete is rejected. The input never stalls, so `in_ready` stays high outside reset.

Top module: `frame_hdr_parser`

## Requirements
- R1: The first fourteen bytes of a frame are decoded as destination MAC (bytes 0 to 5), source MAC (bytes 6 to 11) and EtherType (bytes 12 and 13). Each field is assembled with the earliest byte as its most significant byte.
- R2: When the EtherType equals 0x8100, bytes 14 to 17 are decoded as a tag. PCP is byte 14 bits 7:5, DEI is byte 14 bit 4, VID is byte 14 bits 3:0 followed by byte 15, and the inner EtherType is byte 16 followed by byte 17. Any other EtherType (for example 0x8101 or 0x0081) accepts the frame without a tag.
- R3: `eth_valid` is 1 only when all fourteen Ethernet bytes were extracted, and `tag_valid` is 1 only when all four tag bytes were extracted. All fields of a header that was not extracted read zero.
- R4: A frame whose end-of-frame beat falls before byte 13 is rejected with `res_drop`=1 and `eth_valid`=0. A frame of exactly fourteen bytes without a tag is accepted.
- R5: A tagged frame whose end-of-frame beat falls on bytes 13 to 16 is rejected with `res_drop`=1, `eth_valid`=1 and `tag_valid`=0. A tagged frame of exactly eighteen bytes is accepted.
- R6: `res_valid` is high for one cycle, starting one clock after the deciding beat. The deciding beat is byte 13 for an untagged frame, byte 17 for a tagged frame, or the end-of-frame beat of a short frame. All result outputs change only in a cycle where `res_valid` is high and hold their values in every other cycle. `res_drop` encodes 1 = reject and 0 = accept.
- R7: Payload beats after the decision do not change any output and do not produce another result.
- R8: `res_port` is the value of `in_port` on the start-of-frame beat. Changes of `in_port` on later beats are ignored.
- R9: Beats with `in_valid`=0 are ignored, whatever `in_sof`/`in_eof` show. A valid beat without start-of-frame while no frame is open is ignored. A start-of-frame beat always begins a new frame at byte 0, and an unfinished frame it interrupts gives no result.
- R10: After reset `res_valid`, `res_drop`, both presence flags, the port and all fields are zero, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Beat accepted; high outside reset |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Beat carries byte 0 of a frame |
| in_eof | input | 1 | Beat carries the last byte of a frame |
| in_port | input | PORT_W | Ingress port number, sampled on start-of-frame |
| res_valid | output | 1 | One-cycle result strobe |
| res_drop | output | 1 | 1 = frame rejected, 0 = accepted |
| res_port | output | PORT_W | Ingress port of the reported frame |
| eth_valid | output | 1 | Ethernet header was extracted |
| eth_dst | output | 48 | Destination MAC |
| eth_src | output | 48 | Source MAC |
| eth_type | output | 16 | Outer EtherType |
| tag_valid | output | 1 | Tag was extracted |
| tag_pcp | output | 3 | Tag priority code |
| tag_dei | output | 1 | Tag drop-eligible bit |
| tag_vid | output | 12 | Tag VLAN identifier |
| tag_type | output | 16 | Inner EtherType |

## Verification
Some relations hold on every cycle, and the assertions check them there. The outputs hold between result strobes. A tag is never reported without an Ethernet header. The presence of a tag agrees with the outer EtherType. A rejected frame that still has an Ethernet header is always a truncated tagged frame. The fields of an absent header are zero. Other behaviours only the bench's scenarios can show: the exact byte-to-field mapping, the cycle of each strobe, and the boundary lengths 13/14 and 17/18. The same holds for the port taken from the start-of-frame beat, for restart on a new start-of-frame, and for the silence on stray beats and payload.

// File: rtl/fhp_pkg.sv
package fhp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ETH_BYTES = 14;
  localparam int unsigned TAG_BYTES = 4;
  localparam int unsigned HDR_BYTES = ETH_BYTES + TAG_BYTES;
  localparam int unsigned MAC_W     = 48;
  localparam int unsigned TYPE_W    = 16;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_ETH,
    PS_TAG,
    PS_SKIP
  } pstate_t;

  typedef struct packed {
    logic [MAC_W-1:0]  dst;
    logic [MAC_W-1:0]  src;
    logic [TYPE_W-1:0] etype;
  } eth_fields_t;

  typedef struct packed {
    logic [2:0]        pcp;
    logic              dei;
    logic [11:0]       vid;
    logic [TYPE_W-1:0] inner;
  } tag_fields_t;
endpackage

// File: rtl/fhp_walker.sv
module fhp_walker
  import fhp_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TAG_TYPE = 16'h8100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              sof,
  input  logic              eof,
  input  logic [TYPE_W-1:0] live_type,
  output logic              cap_eth,
  output logic              done,
  output logic              accept,
  output logic              eth_ok,
  output logic              tag_ok,
  output logic              eth_live
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES);
  localparam logic [IDX_W-1:0] ETH_LAST = IDX_W'(ETH_BYTES - 1);
  localparam logic [IDX_W-1:0] TAG_LAST = IDX_W'(HDR_BYTES - 1);

  pstate_t          state, nxt_state;
  logic [IDX_W-1:0] idx, nxt_idx, pos;

  always_comb begin
    nxt_state = state;
    nxt_idx   = idx;
    cap_eth   = 1'b0;
    done      = 1'b0;
    accept    = 1'b0;
    eth_ok    = 1'b0;
    tag_ok    = 1'b0;
    eth_live  = 1'b0;
    pos       = sof ? '0 : idx;
    if (beat) begin
      if (sof || state == PS_ETH) begin
        if (pos == ETH_LAST) begin
          cap_eth = 1'b1;
          if (live_type == TAG_TYPE) begin
            if (eof) begin
              done      = 1'b1;
              eth_ok    = 1'b1;
              eth_live  = 1'b1;
              nxt_state = PS_IDLE;
            end else begin
              nxt_state = PS_TAG;
              nxt_idx   = pos + 1'b1;
            end
          end else begin
            done      = 1'b1;
            accept    = 1'b1;
            eth_ok    = 1'b1;
            eth_live  = 1'b1;
            nxt_state = eof ? PS_IDLE : PS_SKIP;
          end
        end else if (eof) begin
          done      = 1'b1;
          nxt_state = PS_IDLE;
        end else begin
          nxt_state = PS_ETH;
          nxt_idx   = pos + 1'b1;
        end
      end else if (state == PS_TAG) begin
        if (pos == TAG_LAST) begin
          done      = 1'b1;
          accept    = 1'b1;
          eth_ok    = 1'b1;
          tag_ok    = 1'b1;
          nxt_state = eof ? PS_IDLE : PS_SKIP;
        end else if (eof) begin
          done      = 1'b1;
          eth_ok    = 1'b1;
          nxt_state = PS_IDLE;
        end else begin
          nxt_idx = pos + 1'b1;
        end
      end else if (state == PS_SKIP && eof) begin
        nxt_state = PS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_IDLE;
      idx   <= '0;
    end else begin
      state <= nxt_state;
      idx   <= nxt_idx;
    end
  end
endmodule

// File: rtl/fhp_capture.sv
module fhp_capture
  import fhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [BYTE_W-1:0] data,
  input  logic              cap_eth,
  output eth_fields_t       live_eth,
  output eth_fields_t       held_eth,
  output tag_fields_t       live_tag,
  output logic [TYPE_W-1:0] live_type
);
  localparam int unsigned LANES  = ETH_BYTES - 1;
  localparam int unsigned FLAT_W = LANES * BYTE_W;
  localparam int unsigned TAGH_W = (TAG_BYTES - 1) * BYTE_W;

  logic [BYTE_W-1:0] lane [LANES];
  logic [FLAT_W-1:0] flat;

  always_ff @(posedge clk) begin
    if (beat) lane[0] <= data;
  end

  for (genvar g = 1; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (beat) lane[g] <= lane[g-1];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_flat
    assign flat[g*BYTE_W +: BYTE_W] = lane[g];
  end

  assign live_eth  = {flat, data};
  assign live_tag  = {flat[TAGH_W-1:0], data};
  assign live_type = {flat[BYTE_W-1:0], data};

  always_ff @(posedge clk) begin
    if (rst)                  held_eth <= '0;
    else if (beat && cap_eth) held_eth <= live_eth;
  end
endmodule

// File: rtl/fhp_result.sv
module fhp_result
  import fhp_pkg::*;
#(
  parameter int unsigned PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              sof,
  input  logic [PORT_W-1:0] port_in,
  input  logic              done,
  input  logic              accept,
  input  logic              eth_ok,
  input  logic              tag_ok,
  input  logic              eth_live,
  input  eth_fields_t       live_eth,
  input  eth_fields_t       held_eth,
  input  tag_fields_t       live_tag,
  output logic              res_valid,
  output logic              res_drop,
  output logic [PORT_W-1:0] res_port,
  output logic              eth_valid,
  output eth_fields_t       eth_q,
  output logic              tag_valid,
  output tag_fields_t       tag_q
);
  logic [PORT_W-1:0] port_hold;

  always_ff @(posedge clk) begin
    if (rst)              port_hold <= '0;
    else if (beat && sof) port_hold <= port_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_drop  <= 1'b0;
      res_port  <= '0;
      eth_valid <= 1'b0;
      eth_q     <= '0;
      tag_valid <= 1'b0;
      tag_q     <= '0;
    end else begin
      res_valid <= done;
      if (done) begin
        res_drop  <= ~accept;
        res_port  <= sof ? port_in : port_hold;
        eth_valid <= eth_ok;
        eth_q     <= eth_ok ? (eth_live ? live_eth : held_eth) : '0;
        tag_valid <= tag_ok;
        tag_q     <= tag_ok ? live_tag : '0;
      end
    end
  end
endmodule

// File: rtl/frame_hdr_parser.sv
module frame_hdr_parser
  import fhp_pkg::*;
#(
  parameter int unsigned       PORT_W   = 16,
  parameter logic [TYPE_W-1:0] TAG_TYPE = 16'h8100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [PORT_W-1:0] in_port,
  output logic              res_valid,
  output logic              res_drop,
  output logic [PORT_W-1:0] res_port,
  output logic              eth_valid,
  output logic [47:0]       eth_dst,
  output logic [47:0]       eth_src,
  output logic [15:0]       eth_type,
  output logic              tag_valid,
  output logic [2:0]        tag_pcp,
  output logic              tag_dei,
  output logic [11:0]       tag_vid,
  output logic [15:0]       tag_type
);
  logic              beat;
  logic              cap_eth, done, accept, eth_ok, tag_ok, eth_live;
  logic [TYPE_W-1:0] live_type;
  eth_fields_t       live_eth, held_eth, eth_q;
  tag_fields_t       live_tag, tag_q;

  assign in_ready = 1'b1;
  assign beat     = in_valid;

  fhp_walker #(.TAG_TYPE(TAG_TYPE)) u_walk (
    .clk(clk), .rst(rst), .beat(beat), .sof(in_sof), .eof(in_eof),
    .live_type(live_type), .cap_eth(cap_eth), .done(done),
    .accept(accept), .eth_ok(eth_ok), .tag_ok(tag_ok), .eth_live(eth_live)
  );

  fhp_capture u_cap (
    .clk(clk), .rst(rst), .beat(beat), .data(in_data), .cap_eth(cap_eth),
    .live_eth(live_eth), .held_eth(held_eth), .live_tag(live_tag),
    .live_type(live_type)
  );

  fhp_result #(.PORT_W(PORT_W)) u_res (
    .clk(clk), .rst(rst), .beat(beat), .sof(in_sof), .port_in(in_port),
    .done(done), .accept(accept), .eth_ok(eth_ok), .tag_ok(tag_ok),
    .eth_live(eth_live), .live_eth(live_eth), .held_eth(held_eth),
    .live_tag(live_tag), .res_valid(res_valid), .res_drop(res_drop),
    .res_port(res_port), .eth_valid(eth_valid), .eth_q(eth_q),
    .tag_valid(tag_valid), .tag_q(tag_q)
  );

  assign eth_dst  = eth_q.dst;
  assign eth_src  = eth_q.src;
  assign eth_type = eth_q.etype;
  assign tag_pcp  = tag_q.pcp;
  assign tag_dei  = tag_q.dei;
  assign tag_vid  = tag_q.vid;
  assign tag_type = tag_q.inner;
endmodule

// File: rtl/frame_hdr_parser_chk.sv
module frame_hdr_parser_chk #(
  parameter int unsigned PORT_W   = 16,
  parameter logic [15:0] TAG_TYPE = 16'h8100
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic              res_drop,
  input logic [PORT_W-1:0] res_port,
  input logic              eth_valid,
  input logic [47:0]       eth_dst,
  input logic [47:0]       eth_src,
  input logic [15:0]       eth_type,
  input logic              tag_valid,
  input logic [2:0]        tag_pcp,
  input logic              tag_dei,
  input logic [11:0]       tag_vid,
  input logic [15:0]       tag_type
);
  assert_hold_between_results_R6: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable({res_drop, res_port, eth_valid, eth_dst, eth_src, eth_type,
                            tag_valid, tag_pcp, tag_dei, tag_vid, tag_type}));

  assert_tag_needs_eth_R3: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> eth_valid);

  assert_accept_has_eth_R1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_drop) |-> eth_valid);

  assert_tag_matches_type_R2: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> (eth_type == TAG_TYPE));

  assert_tagged_accept_has_tag_R2: assert property (@(posedge clk) disable iff (rst)
    (eth_valid && !res_drop && eth_type == TAG_TYPE) |-> tag_valid);

  assert_short_tag_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (res_drop && eth_valid) |-> (eth_type == TAG_TYPE && !tag_valid));

  assert_absent_eth_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !eth_valid |-> (eth_dst == 48'd0 && eth_src == 48'd0 && eth_type == 16'd0));

  assert_absent_tag_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !tag_valid |-> (tag_pcp == 3'd0 && !tag_dei && tag_vid == 12'd0 && tag_type == 16'd0));

  assert_short_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (res_drop && !eth_valid) |-> !tag_valid);
endmodule

bind frame_hdr_parser frame_hdr_parser_chk #(.PORT_W(PORT_W), .TAG_TYPE(TAG_TYPE)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_drop(res_drop),
  .res_port(res_port), .eth_valid(eth_valid), .eth_dst(eth_dst),
  .eth_src(eth_src), .eth_type(eth_type), .tag_valid(tag_valid),
  .tag_pcp(tag_pcp), .tag_dei(tag_dei), .tag_vid(tag_vid), .tag_type(tag_type)
);

// File: tb/frame_hdr_parser_test.sv
module frame_hdr_parser_test;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_ready;
  logic [7:0]    in_data = 8'h00;
  logic [PW-1:0] in_port = '0;
  logic          res_valid, res_drop, eth_valid, tag_valid, tag_dei;
  logic [PW-1:0] res_port;
  logic [47:0]   eth_dst, eth_src;
  logic [15:0]   eth_type, tag_type;
  logic [2:0]    tag_pcp;
  logic [11:0]   tag_vid;

  frame_hdr_parser #(.PORT_W(PW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_port(in_port),
    .res_valid(res_valid), .res_drop(res_drop), .res_port(res_port),
    .eth_valid(eth_valid), .eth_dst(eth_dst), .eth_src(eth_src),
    .eth_type(eth_type), .tag_valid(tag_valid), .tag_pcp(tag_pcp),
    .tag_dei(tag_dei), .tag_vid(tag_vid), .tag_type(tag_type)
  );

  typedef struct {
    logic [47:0] dst, src;
    logic [15:0] et, it;
    logic [2:0]  pcp;
    logic        dei;
    logic [11:0] vid;
    logic        ev, tv, drop;
    logic [15:0] port;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t       q[$];
  exp_t       last, got;
  bit         have_last = 1'b0;
  int         checks = 0, errors = 0, cyc = 0;
  logic [7:0] fb [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(exp_t e, string tag);
    cmp(tag, "res_drop", res_drop, e.drop);
    cmp(tag, "res_port", res_port, e.port);
    cmp(tag, "eth_valid", eth_valid, e.ev);
    cmp(tag, "eth_dst", eth_dst, e.dst);
    cmp(tag, "eth_src", eth_src, e.src);
    cmp(tag, "eth_type", eth_type, e.et);
    cmp(tag, "tag_valid", tag_valid, e.tv);
    cmp(tag, "tag_pcp", tag_pcp, e.pcp);
    cmp(tag, "tag_dei", tag_dei, e.dei);
    cmp(tag, "tag_vid", tag_vid, e.vid);
    cmp(tag, "tag_type", tag_type, e.it);
  endtask

  // expected result from the requirement text, byte by byte
  function automatic exp_t model(int len, logic [15:0] port, string tag);
    exp_t e;
    e.dst = '0; e.src = '0; e.et = '0; e.it = '0; e.pcp = '0; e.dei = 1'b0;
    e.vid = '0; e.ev = 1'b0; e.tv = 1'b0; e.drop = 1'b0; e.port = port;
    e.cyc = 0; e.tag = tag;
    if (len < 14) begin
      e.drop = 1'b1;                                   // R4
    end else begin
      e.ev = 1'b1;
      for (int i = 0; i < 6; i++) e.dst = {e.dst[39:0], fb[i]};
      for (int i = 6; i < 12; i++) e.src = {e.src[39:0], fb[i]};
      e.et = {fb[12], fb[13]};
      if (e.et == 16'h8100) begin
        if (len < 18) e.drop = 1'b1;                   // R5
        else begin
          e.tv  = 1'b1;                                // R2
          e.pcp = fb[14][7:5];
          e.dei = fb[14][4];
          e.vid = {fb[14][3:0], fb[15]};
          e.it  = {fb[16], fb[17]};
        end
      end
    end
    return e;
  endfunction

  task automatic fill(logic [47:0] d, logic [47:0] s, logic [15:0] et, logic [31:0] tagw);
    for (int i = 0; i < 6; i++) fb[i] = d[47-8*i -: 8];
    for (int i = 0; i < 6; i++) fb[6+i] = s[47-8*i -: 8];
    fb[12] = et[15:8];
    fb[13] = et[7:0];
    for (int i = 0; i < 4; i++) fb[14+i] = tagw[31-8*i -: 8];
    for (int i = 18; i < 64; i++) fb[i] = 8'(i * 7 + 3);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  // driver: plays a frame and queues the expected result on the deciding beat
  task automatic send(int len, bit with_eof, logic [15:0] port, int gap, string tag);
    exp_t e;
    int   dec;
    bit   has_dec;
    e = model(len, port, tag);
    if (len < 14) dec = len - 1;
    else if ({fb[12], fb[13]} != 16'h8100) dec = 13;
    else if (len < 18) dec = len - 1;
    else dec = 17;
    has_dec = with_eof || (len >= 14 && {fb[12], fb[13]} != 16'h8100) || (len >= 18);
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk);                                // R9 invalid beat with markers
        in_valid = 1'b0; in_data = 8'hA5; in_sof = 1'b1; in_eof = 1'b1;
        in_port = 16'hDEAD;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == len - 1);
      in_port  = (i == 0) ? port : ~port;              // R8
      if (has_dec && i == dec) begin
        e.cyc = cyc + 1;
        q.push_back(e);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i % 2) == 1;
      in_data = 8'(8'h81 + i); in_port = 16'h0BAD;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
  endtask

  // monitor: pops one expected item per strobe, checks hold otherwise
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected result strobe actual=1 expected=0");
        end else begin
          got = q.pop_front();
          cmp("R6", "strobe_cycle", 64'(cyc), 64'(got.cyc));
          cmp_all(got, got.tag);
          last = got;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        cmp_all(last, "R7");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    cmp("R10", "in_ready", in_ready, 1'b1);
    cmp("R10", "res_valid", res_valid, 1'b0);
    cmp("R10", "res_drop", res_drop, 1'b0);
    cmp("R10", "eth_valid", eth_valid, 1'b0);
    cmp("R10", "tag_valid", tag_valid, 1'b0);
    cmp("R10", "eth_dst", eth_dst, 48'd0);
    cmp("R10", "res_port", res_port, '0);

    // R1 minimal untagged frame
    fill(48'h0A1B2C3D4E5F, 48'h112233445566, 16'h0800, 32'h0);
    send(14, 1'b1, 16'd3, 0, "R1");
    idle(2);
    // R7 untagged with payload and invalid gaps
    fill(48'hFFEEDDCCBBAA, 48'h0102030405F6, 16'h86DD, 32'h12345678);
    send(40, 1'b1, 16'd7, 5, "R7");
    idle(2);
    // R2 tagged, exactly 18 bytes
    fill(48'h000102030405, 48'h060708090A0B, 16'h8100, 32'hB7FE0800);
    send(18, 1'b1, 16'd1, 0, "R2");
    idle(1);
    // R8 tagged with payload, port toggles after start
    fill(48'hC0FFEE000001, 48'hBEEF00000002, 16'h8100, 32'h4ABC88CC);
    send(30, 1'b1, 16'h00F0, 3, "R8");
    // R2 near-miss tag identifiers are untagged
    fill(48'h1, 48'h2, 16'h8101, 32'hFFFFFFFF);
    send(20, 1'b1, 16'd4, 0, "R2");
    fill(48'h3, 48'h4, 16'h0081, 32'hFFFFFFFF);
    send(20, 1'b1, 16'd5, 0, "R2");
    // R4 short frames
    fill(48'h5, 48'h6, 16'h0800, 32'h0);
    send(1, 1'b1, 16'd9, 0, "R4");
    send(5, 1'b1, 16'd10, 0, "R4");
    send(13, 1'b1, 16'd11, 0, "R4");
    // R5 truncated tagged frames
    fill(48'hAABBCCDDEEFF, 48'h998877665544, 16'h8100, 32'h2FFF0806);
    send(14, 1'b1, 16'd12, 0, "R5");
    send(16, 1'b1, 16'd13, 0, "R5");
    send(17, 1'b1, 16'd14, 2, "R5");
    // R9 stray beats while idle
    stray(6);
    idle(2);
    // R9 restart: unfinished frame interrupted by a new start
    fill(48'h777777777777, 48'h888888888888, 16'h8100, 32'h00010800);
    send(9, 1'b0, 16'd20, 0, "R9");
    send(16, 1'b0, 16'd21, 0, "R9");
    fill(48'h123456789ABC, 48'hDEF012345678, 16'h0806, 32'h0);
    send(22, 1'b1, 16'd22, 0, "R9");
    // back-to-back, no idle
    fill(48'h0, 48'hFFFFFFFFFFFF, 16'h8100, 32'hE0010000);
    send(18, 1'b1, 16'hFFFF, 0, "R2");
    send(3, 1'b1, 16'd0, 0, "R4");
    idle(6);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 results outstanding actual=%0d expected=0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule